// File: doc/BRIEF.md
# Completion Event Interrupt Controller

This block sits beside a queued command engine and turns the completion of wait commands into message-signalled interrupt requests. Each time a wait command finishes, the engine pulses `wait_done_i` and presents that command's interrupt-request flag on `wait_irq_i`. Only a completion with the flag set is an interrupt condition.

Three bits of state govern the flow. A wait-completion status bit records that a condition was taken and blocks further conditions until software clears it. An interrupt-pending bit holds an event that has not yet been delivered. An interrupt-mask bit decides whether a pending event is delivered at once or held. Software sees all three bits through a small register port. It may write the mask and write-one-to-clear the status bit. Clearing the status bit also discards any held event. A delivered event drives `msg_req_o`, which is held until the fabric acknowledges it.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: After reset, status and pending read 0, mask reads 1 and `msg_req_o` is low.
- R2: A completion pulse with the flag clear, or the flag without a pulse, changes no state and raises no request.
- R3: A condition (pulse with flag set) while status is 0 sets both status and pending at the next clock edge.
- R4: A condition while status is 1 is ignored: pending, mask and the request output keep their values.
- R5: With pending 1, mask 0 and no request outstanding, `msg_req_o` rises one cycle later. It stays high until `msg_ack_i` is sampled high, and pending clears on that same edge.
- R6: While mask is 1, a pending event is held and no new request is raised.
- R7: Clearing the mask while pending is 1 raises one request one cycle after the write.
- R8: The read word is bit 0 status, bit 1 pending, bit 2 mask. A write loads mask from bit 2 of the write data. Writing 1 to bit 0 clears status and pending together, which drops a held event. Writing 0 to bit 0 or any value to bit 1 changes neither bit.
- R9: If a condition and a status clear fall in the same cycle, the clear is applied first, so status and pending end at 1.
- R10: At most one request is outstanding. A condition accepted while a request is outstanding keeps pending at 1, and a fresh request follows once the current one is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_done_i | input | 1 | One-cycle pulse: a wait command completed |
| wait_irq_i | input | 1 | Interrupt-request flag of the completing command |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 3 | Write data: bit 2 mask, bit 1 ignored, bit 0 status clear |
| reg_rdata_o | output | 3 | Read data: bit 2 mask, bit 1 pending, bit 0 status |
| msg_req_o | output | 1 | Message request, held until acknowledged |
| msg_ack_i | input | 1 | Acknowledge of the outstanding request |

## Verification
Two collisions matter most here. The first is a completion condition landing in the same cycle as a software clear of the status bit. The second is a new condition, a status clear and an acknowledge of the outstanding request all landing in one cycle. The stimulus table drives each collision with all inputs set together before a single edge. It then judges the register readback and request line on the next sample, and again one cycle later, to confirm that the recorded event produces exactly one further request.

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_done_i,
  input  logic             wait_irq_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             msg_req_o,
  input  logic             msg_ack_i
);
  localparam int STAT_B = 0;
  localparam int PEND_B = 1;
  localparam int MASK_B = 2;

  logic stat_q, pend_q, mask_q, req_q;

  wire cond   = wait_done_i & wait_irq_i;
  wire sw_clr = reg_wr_i & reg_wdata_i[STAT_B];
  wire take   = cond & (~stat_q | sw_clr);
  wire acked  = req_q & msg_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
      mask_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      if (take)        stat_q <= 1'b1;
      else if (sw_clr) stat_q <= 1'b0;

      if (take)                 pend_q <= 1'b1;
      else if (sw_clr || acked) pend_q <= 1'b0;

      if (reg_wr_i) mask_q <= reg_wdata_i[MASK_B];

      if (req_q) req_q <= ~msg_ack_i;
      else       req_q <= pend_q & ~mask_q;
    end
  end

  always_comb begin
    reg_rdata_o         = '0;
    reg_rdata_o[STAT_B] = stat_q;
    reg_rdata_o[PEND_B] = pend_q;
    reg_rdata_o[MASK_B] = mask_q;
  end

  assign msg_req_o = req_q;
endmodule

module cmpl_irq_ctrl_chk #(
  parameter int REG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_done_i,
  input logic             wait_irq_i,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             msg_req_o,
  input logic             msg_ack_i
);
  wire st  = reg_rdata_o[0];
  wire pd  = reg_rdata_o[1];
  wire mk  = reg_rdata_o[2];
  wire cnd = wait_done_i & wait_irq_i;
  wire clr = reg_wr_i & reg_wdata_i[0];

  assert_take_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnd && !st |=> st && pd);
  assert_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnd && st && !clr && !msg_req_o |=> $stable(pd));
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req_o && !msg_ack_i |=> msg_req_o);
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req_o && msg_ack_i && !cnd |=> !pd && !msg_req_o);
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mk && !msg_req_o |=> !msg_req_o);
  assert_unmasked_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd && !mk && !msg_req_o |=> msg_req_o);
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !cnd |=> !st && !pd);
  assert_clear_then_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr && cnd |=> st && pd);
endmodule

bind cmpl_irq_ctrl cmpl_irq_ctrl_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/cmpl_irq_ctrl_tb_top.sv
module cmpl_irq_ctrl_tb_top;
  // Requirements covered: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_done_i = 1'b0, wait_irq_i = 1'b0, reg_wr_i = 1'b0, msg_ack_i = 1'b0;
  logic [2:0] reg_wdata_i = '0;
  logic [2:0] reg_rdata_o;
  logic msg_req_o;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmpl_irq_ctrl dut_i (.*);

  // {done,irq,wr}, wdata{mask,pend,stat}, ack, exp{req,mask,pend,stat}, req id
  localparam int NV = 31;
  localparam logic [14:0] VEC [NV] = '{
    15'b100_000_0_0100_0010, // R2
    15'b110_000_0_0111_0011, // R3
    15'b000_000_0_0111_0110, // R6
    15'b110_000_0_0111_0100, // R4
    15'b001_110_0_0111_1000, // R8 pend read-only
    15'b001_000_0_0011_1000, // R8 write 0 to status
    15'b000_000_0_1011_0111, // R7
    15'b000_000_0_1011_0101, // R5 hold
    15'b000_000_1_0001_0101, // R5 ack
    15'b000_000_0_0001_0101, // R5 no repeat
    15'b110_000_0_0001_0100, // R4
    15'b001_001_0_0000_1000, // R8
    15'b110_000_0_0011_0011, // R3
    15'b000_000_0_1011_0101, // R5
    15'b001_001_0_1000_1000, // R8 clear while outstanding
    15'b000_000_1_0000_1010, // R10
    15'b110_000_0_0011_0011, // R3
    15'b000_000_0_1011_0101, // R5
    15'b000_000_1_0001_0101, // R5
    15'b111_001_0_0011_1001, // R9
    15'b000_000_0_1011_0101, // R5
    15'b111_001_1_0011_1010, // R10 clear+cond+ack
    15'b000_000_0_1011_1010, // R10 second request
    15'b000_000_1_0001_0101, // R5
    15'b001_101_0_0100_1000, // R8
    15'b110_000_0_0111_0110, // R6
    15'b000_000_0_0111_0110, // R6
    15'b001_101_0_0100_1000, // R8 drop held event
    15'b001_000_0_0000_0111, // R7 nothing pending
    15'b000_000_0_0000_1000, // R8 dropped, no request
    15'b010_000_0_0000_0010  // R2
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {req,mask,pend,stat} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {msg_req_o, reg_rdata_o}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {msg_req_o, reg_rdata_o}, 4'b0100);

    for (int i = 0; i < NV; i++) begin
      {wait_done_i, wait_irq_i, reg_wr_i} = VEC[i][14:12];
      reg_wdata_i = VEC[i][11:9];
      msg_ack_i   = VEC[i][8];
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {msg_req_o, reg_rdata_o}, VEC[i][7:4]);
    end
    {wait_done_i, wait_irq_i, reg_wr_i, msg_ack_i} = '0;
    reg_wdata_i = '0;

    // R5: long hold without acknowledge
    wait_done_i = 1'b1; wait_irq_i = 1'b1;
    @(negedge clk);
    wait_done_i = 1'b0; wait_irq_i = 1'b0;
    repeat (20) @(negedge clk);
    check("R5 long hold", {msg_req_o, reg_rdata_o}, 4'b1011);

    // R1: reset in mid-flight returns to reset state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", {msg_req_o, reg_rdata_o}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays idle", {msg_req_o, reg_rdata_o}, 4'b0100);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule